// File: doc/BRIEF.md
# Four-Tap Pre-Emphasis Weight Combiner

This block is a cycle-accurate digital model of a four-tap feed-forward pre-emphasis output driver. A serial data bit is shifted into a four-stage delay line on every clock, which yields four delayed copies of the stream (tap 1 is the newest, tap 4 the oldest). Each tap has its own polarity control. The weight of a tap is not a free coefficient. It is built from a fixed pool of unit buffers: seven switchable buffers, each worth exactly one eighth of full amplitude, whose tap assignment is restricted, plus one analog trim per tap that ranges from zero up to one eighth.

Each cycle the block produces a registered signed amplitude. This is the sum of the tap weights, each added when the tap's effective bit is 1 and subtracted when it is 0. The value is expressed in fixed-point units of 1/2040 of full amplitude when the analog code is 8 bits wide. Two configuration checks run alongside the sum. One flags a weight pool whose total exceeds full amplitude. The other flags a tap that carries more than one sixteenth of full amplitude while its extra half-current enable is off. All configuration arrives as parallel inputs and is sampled on every clock.

Top module: `preemph_tap_combiner`

## Requirements
- R1: On each rising clock edge with `rst` low, tap 1 takes `din` and tap k+1 takes the old value of tap k. A bit driven on `din` at edge n therefore reaches tap 2 at edge n+1.
- R2: `tap_inv[k]` = 1 inverts the bit of tap k+1 before it is weighted, and 0 leaves it direct. Inversion of one tap does not change any other tap's contribution.
- R3: Switchable buffer b+1 is controlled by `buf_en[b]`. When enabled, it adds 2^CODE_W-1 units (255 by default) to exactly one tap. With `buf_steer[b]` = 0 it goes to its home tap: tap 1 for buffers 1-2, tap 3 for buffers 3-5 and tap 4 for buffers 6-7. With `buf_steer[b]` = 1 it goes to tap 2.
- R4: The analog trim of tap k+1 is the unsigned code `ana_code[CODE_W*k +: CODE_W]`, and it adds that many units only when `ana_en[k]` = 1. With `ana_en[k]` = 0 the code has no effect.
- R5: `amp_out` is the two's-complement sum over taps of +weight (effective bit 1) or -weight (effective bit 0). It is registered: the value present after edge n is computed from the taps as they stood before edge n and the configuration sampled at edge n. Its magnitude never exceeds 11·(2^CODE_W-1).
- R6: `over_flag` is 1 when the sum of all tap weights exceeds 8·(2^CODE_W-1) units (2040 by default), and 0 when it is equal or lower. It is registered with the same timing as `amp_out`.
- R7: `half_warn` is 1 when any tap k+1 has twice its weight greater than 2^CODE_W-1 (weight above 127 by default, i.e. above one sixteenth of full amplitude) while `half_en[k]` = 0. It is registered with the same timing as `amp_out`.
- R8: A synchronous reset (`rst` high at a rising edge) clears the delay line, `amp_out`, `over_flag` and `half_warn` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal bit clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| tap_inv | input | 4 | Per-tap polarity inversion, bit k for tap k+1 |
| buf_en | input | 7 | Switchable buffer enables, bit b for buffer b+1 |
| buf_steer | input | 7 | Buffer steering, 0 = home tap, 1 = tap 2 |
| ana_en | input | 4 | Per-tap analog trim enable |
| ana_code | input | 4*CODE_W | Packed analog trim codes, tap k+1 at bits CODE_W*k upward |
| half_en | input | 4 | Per-tap extra half-current enable |
| amp_out | output | SUM_W (13) | Registered signed amplitude sum |
| over_flag | output | 1 | Registered total-weight overrange flag |
| half_warn | output | 1 | Registered half-current warning flag |

## Verification
The assertions check several behaviours on every cycle. These are the shift of the delay line, the cleared state after reset, the amplitude bound, the silence of the output and the overrange flag when no buffer is enabled, the absence of overrange when at most eight weight sources are active, and the absence of the warning when every half-current enable is on. The exact signed sum under arbitrary steering and inversion, the precise overrange boundary at 2040 against 2041 units, and the warning threshold at 127 against 128 units can only be shown by the bench's scenarios. The bench compares these against an arithmetic model over a sweep of all 128 buffer-enable patterns.

// File: rtl/preemph_pkg.sv
package preemph_pkg;

   localparam int NUM_TAPS     = 4;
   localparam int NUM_DIG      = 7;
   localparam int SHARED_TAP   = 1;
   localparam int FULL_EIGHTHS = 8;

   typedef enum logic {
      STEER_HOME   = 1'b0,
      STEER_SHARED = 1'b1
   } steer_e;

   // Home tap (zero based) of switchable buffer idx (zero based)
   function automatic int home_tap(input int idx);
      if (idx < 2)      return 0;
      else if (idx < 5) return 2;
      else              return 3;
   endfunction

endpackage

// File: rtl/preemph_delay_line.sv
module preemph_delay_line #(
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             din,
   output logic [DEPTH-1:0] taps
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("preemph_delay_line: DEPTH must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) taps <= '0;
      else     taps <= {taps[DEPTH-2:0], din};
   end

endmodule

// File: rtl/preemph_tap_weight.sv
module preemph_tap_weight
   import preemph_pkg::*;
#(
   parameter int CODE_W  = 8,
   parameter int TAP_IDX = 0,
   parameter int W_W     = 11
) (
   input  logic [NUM_DIG-1:0] buf_en,
   input  logic [NUM_DIG-1:0] buf_steer,
   input  logic               ana_en,
   input  logic [CODE_W-1:0]  ana_code,
   output logic [W_W-1:0]     weight
);

   localparam int UNIT  = (1 << CODE_W) - 1;
   localparam int CNT_W = $clog2(NUM_DIG + 1);

   if (W_W < $clog2((NUM_DIG + 1) * UNIT + 1)) begin : g_bad_width
      $error("preemph_tap_weight: W_W too narrow for the pool");
   end
   if (TAP_IDX < 0 || TAP_IDX >= NUM_TAPS) begin : g_bad_tap
      $error("preemph_tap_weight: TAP_IDX out of range");
   end

   logic [NUM_DIG-1:0] owns;
   logic [CNT_W-1:0]   cnt;

   for (genvar b = 0; b < NUM_DIG; b++) begin : g_buf
      localparam bit AT_HOME   = (home_tap(b) == TAP_IDX);
      localparam bit IS_SHARED = (TAP_IDX == SHARED_TAP);
      assign owns[b] = buf_en[b] &
                       ((AT_HOME   && (buf_steer[b] == STEER_HOME)) ||
                        (IS_SHARED && (buf_steer[b] == STEER_SHARED)));
   end

   always_comb begin
      cnt = '0;
      for (int b = 0; b < NUM_DIG; b++) begin
         cnt = cnt + CNT_W'(owns[b]);
      end
   end

   always_comb begin
      weight = W_W'(cnt) * W_W'(UNIT);
      if (ana_en) weight = weight + W_W'(ana_code);
   end

endmodule

// File: rtl/preemph_sum_stage.sv
module preemph_sum_stage
   import preemph_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int W_W    = 11,
   parameter int MAG_W  = 12,
   parameter int SUM_W  = 13
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [NUM_TAPS-1:0]            tap_pol,
   input  logic [NUM_TAPS-1:0][W_W-1:0]   weight,
   input  logic [NUM_TAPS-1:0]            half_en,
   output logic signed [SUM_W-1:0]        amp_out,
   output logic                           over_flag,
   output logic                           half_warn
);

   localparam int UNIT = (1 << CODE_W) - 1;
   localparam int FULL = FULL_EIGHTHS * UNIT;

   if (SUM_W != MAG_W + 1) begin : g_bad_sum
      $error("preemph_sum_stage: SUM_W must be MAG_W + 1");
   end
   if (MAG_W < $clog2((NUM_DIG + NUM_TAPS) * UNIT + 1)) begin : g_bad_mag
      $error("preemph_sum_stage: MAG_W too narrow");
   end

   logic signed [SUM_W-1:0] sum_d;
   logic [MAG_W-1:0]        mag_d;
   logic                    warn_d;
   logic                    over_d;

   always_comb begin
      sum_d  = '0;
      mag_d  = '0;
      warn_d = 1'b0;
      for (int t = 0; t < NUM_TAPS; t++) begin
         if (tap_pol[t]) sum_d = sum_d + $signed(SUM_W'(weight[t]));
         else            sum_d = sum_d - $signed(SUM_W'(weight[t]));
         mag_d = mag_d + MAG_W'(weight[t]);
         if (({1'b0, weight[t], 1'b0} > (W_W + 2)'(UNIT)) && !half_en[t])
            warn_d = 1'b1;
      end
      over_d = (mag_d > MAG_W'(FULL));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         amp_out   <= '0;
         over_flag <= 1'b0;
         half_warn <= 1'b0;
      end else begin
         amp_out   <= sum_d;
         over_flag <= over_d;
         half_warn <= warn_d;
      end
   end

endmodule

// File: rtl/preemph_tap_combiner.sv
module preemph_tap_combiner
   import preemph_pkg::*;
#(
   parameter  int CODE_W = 8,
   localparam int UNIT   = (1 << CODE_W) - 1,
   localparam int W_W    = $clog2((NUM_DIG + 1) * UNIT + 1),
   localparam int MAG_W  = $clog2((NUM_DIG + NUM_TAPS) * UNIT + 1),
   localparam int SUM_W  = MAG_W + 1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         din,
   input  logic [NUM_TAPS-1:0]          tap_inv,
   input  logic [NUM_DIG-1:0]           buf_en,
   input  logic [NUM_DIG-1:0]           buf_steer,
   input  logic [NUM_TAPS-1:0]          ana_en,
   input  logic [NUM_TAPS*CODE_W-1:0]   ana_code,
   input  logic [NUM_TAPS-1:0]          half_en,
   output logic signed [SUM_W-1:0]      amp_out,
   output logic                         over_flag,
   output logic                         half_warn
);

   if (CODE_W < 2 || CODE_W > 12) begin : g_bad_code
      $error("preemph_tap_combiner: CODE_W must lie in 2..12");
   end

   logic [NUM_TAPS-1:0]          tap_q;
   logic [NUM_TAPS-1:0]          tap_pol;
   logic [NUM_TAPS-1:0][W_W-1:0] tap_w;

   preemph_delay_line #(
      .DEPTH (NUM_TAPS)
   ) dly_i (
      .clk  (clk),
      .rst  (rst),
      .din  (din),
      .taps (tap_q)
   );

   for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
      assign tap_pol[t] = tap_q[t] ^ tap_inv[t];

      preemph_tap_weight #(
         .CODE_W  (CODE_W),
         .TAP_IDX (t),
         .W_W     (W_W)
      ) wt_i (
         .buf_en    (buf_en),
         .buf_steer (buf_steer),
         .ana_en    (ana_en[t]),
         .ana_code  (ana_code[t*CODE_W +: CODE_W]),
         .weight    (tap_w[t])
      );
   end

   preemph_sum_stage #(
      .CODE_W (CODE_W),
      .W_W    (W_W),
      .MAG_W  (MAG_W),
      .SUM_W  (SUM_W)
   ) sum_i (
      .clk       (clk),
      .rst       (rst),
      .tap_pol   (tap_pol),
      .weight    (tap_w),
      .half_en   (half_en),
      .amp_out   (amp_out),
      .over_flag (over_flag),
      .half_warn (half_warn)
   );

endmodule

// File: rtl/preemph_checker.sv
module preemph_checker
   import preemph_pkg::*;
#(
   parameter int CODE_W = 8,
   parameter int SUM_W  = 13
) (
   input logic                    clk,
   input logic                    rst,
   input logic                    din,
   input logic [NUM_TAPS-1:0]     tap_q,
   input logic [NUM_DIG-1:0]      buf_en,
   input logic [NUM_TAPS-1:0]     ana_en,
   input logic [NUM_TAPS-1:0]     half_en,
   input logic signed [SUM_W-1:0] amp_out,
   input logic                    over_flag,
   input logic                    half_warn
);

   localparam int UNIT = (1 << CODE_W) - 1;
   localparam int LIM  = (NUM_DIG + NUM_TAPS) * UNIT;

   a_r1_shift: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> tap_q == {$past(tap_q[NUM_TAPS-2:0]), $past(din)})
      else $error("a_r1_shift");

   a_r8_reset_clear: assert property (@(posedge clk)
      rst |=> (amp_out == '0) && !over_flag && !half_warn && (tap_q == '0))
      else $error("a_r8_reset_clear");

   a_r5_bounded: assert property (@(posedge clk) disable iff (rst)
      (int'(amp_out) <= LIM) && (int'(amp_out) >= -LIM))
      else $error("a_r5_bounded");

   a_r6_idle_pool: assert property (@(posedge clk) disable iff (rst)
      ($past(buf_en) == '0) && ($past(ana_en) == '0) |-> (amp_out == '0) && !over_flag)
      else $error("a_r6_idle_pool");

   a_r6_few_sources: assert property (@(posedge clk) disable iff (rst)
      ($past($countones(buf_en) + $countones(ana_en)) <= FULL_EIGHTHS) |-> !over_flag)
      else $error("a_r6_few_sources");

   a_r7_all_half_on: assert property (@(posedge clk) disable iff (rst)
      (&$past(half_en)) |-> !half_warn)
      else $error("a_r7_all_half_on");

endmodule

bind preemph_tap_combiner preemph_checker #(
   .CODE_W (CODE_W),
   .SUM_W  (SUM_W)
) chk_i (
   .clk       (clk),
   .rst       (rst),
   .din       (din),
   .tap_q     (tap_q),
   .buf_en    (buf_en),
   .ana_en    (ana_en),
   .half_en   (half_en),
   .amp_out   (amp_out),
   .over_flag (over_flag),
   .half_warn (half_warn)
);

// File: tb/preemph_tap_combiner_tb_top.sv
module preemph_tap_combiner_tb_top;

   localparam int UNIT = 255;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              din = 1'b0;
   logic [3:0]        tap_inv = '0;
   logic [6:0]        buf_en = '0;
   logic [6:0]        buf_steer = '0;
   logic [3:0]        ana_en = '0;
   logic [31:0]       ana_code = '0;
   logic [3:0]        half_en = '0;
   logic signed [12:0] amp_out;
   logic              over_flag;
   logic              half_warn;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [3:0] m_sr = '0;
   int m_amp = 0;
   int m_over = 0;
   int m_warn = 0;
   int unsigned seed = 32'h1234_5678;

   always #5 clk = ~clk;

   preemph_tap_combiner dut_i (
      .clk       (clk),
      .rst       (rst),
      .din       (din),
      .tap_inv   (tap_inv),
      .buf_en    (buf_en),
      .buf_steer (buf_steer),
      .ana_en    (ana_en),
      .ana_code  (ana_code),
      .half_en   (half_en),
      .amp_out   (amp_out),
      .over_flag (over_flag),
      .half_warn (half_warn)
   );

   function automatic int unsigned rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed >> 8;
   endfunction

   // weight of tap t (0 based) from the requirement text of R3 and R4
   function automatic int model_weight(input int t);
      int w = 0;
      for (int b = 0; b < 7; b++) begin
         int dest;
         if (buf_steer[b])  dest = 1;
         else if (b < 2)    dest = 0;
         else if (b < 5)    dest = 2;
         else               dest = 3;
         if (buf_en[b] && dest == t) w += UNIT;
      end
      if (ana_en[t]) w += int'(ana_code[t*8 +: 8]);
      return w;
   endfunction

   task automatic tick(input logic d);
      din = d;
      @(posedge clk);
      if (rst) begin
         m_amp = 0; m_over = 0; m_warn = 0; m_sr = '0;
      end else begin
         int mag = 0;
         m_amp = 0; m_warn = 0;
         for (int t = 0; t < 4; t++) begin
            int w = model_weight(t);
            mag += w;
            if (m_sr[t] ^ tap_inv[t]) m_amp += w; else m_amp -= w;
            if (2 * w > UNIT && !half_en[t]) m_warn = 1;
         end
         m_over = (mag > 8 * UNIT) ? 1 : 0;
         m_sr = {m_sr[2:0], d};
      end
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_model(input string tag);
      chk({tag, " R5 amp"}, int'(amp_out), m_amp);
      chk({tag, " R6 over"}, int'(over_flag), m_over);
      chk({tag, " R7 warn"}, int'(half_warn), m_warn);
   endtask

   task automatic clear_cfg();
      tap_inv = '0; buf_en = '0; buf_steer = '0;
      ana_en = '0; ana_code = '0; half_en = 4'hF;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      tick(1'b1);
      tick(1'b1);
      rst = 1'b0;
   endtask

   initial begin
      @(negedge clk);
      clear_cfg();
      do_reset();
      // R8: cleared state after reset
      chk("R8 amp after reset", int'(amp_out), 0);
      chk("R8 over after reset", int'(over_flag), 0);
      chk("R8 warn after reset", int'(half_warn), 0);

      // R1: impulse walks to tap 2 one edge after entering tap 1
      ana_en = 4'b0010; ana_code[15:8] = 8'd100;
      tick(1'b1); chk("R1 before arrival", int'(amp_out), -100);
      tick(1'b0); chk("R1 in tap 1 only", int'(amp_out), -100);
      tick(1'b0); chk("R1 in tap 2", int'(amp_out), 100);
      tick(1'b0); chk("R1 left tap 2", int'(amp_out), -100);

      // R2: inversion of tap 2 flips its sign
      tap_inv = 4'b0010;
      tick(1'b0); tick(1'b0); tick(1'b0); tick(1'b0);
      chk("R2 inverted zero bit", int'(amp_out), 100);
      chk_model("R2");

      // R3: buffer 1 at home tap 1, then steered to tap 2
      clear_cfg();
      buf_en = 7'b0000001;
      tick(1'b1); chk("R3 home tap zero", int'(amp_out), -255);
      tick(1'b0); chk("R3 home tap one", int'(amp_out), 255);
      buf_steer = 7'b0000001;
      tick(1'b0); chk("R3 steered to tap 2", int'(amp_out), 255);
      buf_en = 7'b0010000; buf_steer = '0;
      tick(1'b0); chk_model("R3 buffer 5 at tap 3");

      // R4: analog code ignored while disabled
      clear_cfg();
      ana_code = {4{8'd200}};
      tick(1'b1); chk("R4 analog disabled", int'(amp_out), 0);
      ana_en = 4'b1000;
      tick(1'b0); chk_model("R4 analog enabled");

      // R6: exact full amplitude versus one unit above
      clear_cfg();
      buf_en = 7'h7F; ana_en = 4'b0001; ana_code[7:0] = 8'd255;
      tick(1'b1); chk("R6 total 2040", int'(over_flag), 0);
      ana_en = 4'b0011; ana_code[15:8] = 8'd1;
      tick(1'b0); chk("R6 total 2041", int'(over_flag), 1);
      chk_model("R6 boundary");

      // R8: reset mid-run clears an active overrange
      rst = 1'b1;
      tick(1'b1);
      chk("R8 amp mid reset", int'(amp_out), 0);
      chk("R8 over mid reset", int'(over_flag), 0);
      rst = 1'b0;

      // R7: half-current threshold at 127 versus 128
      clear_cfg();
      half_en = 4'b0000; ana_en = 4'b0001; ana_code[7:0] = 8'd127;
      tick(1'b0); chk("R7 weight 127", int'(half_warn), 0);
      ana_code[7:0] = 8'd128;
      tick(1'b0); chk("R7 weight 128", int'(half_warn), 1);
      half_en = 4'b0001;
      tick(1'b0); chk("R7 half enabled", int'(half_warn), 0);
      buf_en = 7'b0000001; buf_steer = 7'b0000001;
      tick(1'b0); chk("R7 steered to uncovered tap", int'(half_warn), 1);

      // Sweep of every buffer-enable pattern (R3, R4, R5, R6, R7)
      for (int e = 0; e < 128; e++) begin
         for (int s = 0; s < 3; s++) begin
            logic [6:0] ev = 7'(e);
            buf_en    = ev;
            buf_steer = (s == 0) ? 7'h00 : (s == 1) ? 7'h7F : (7'h2A ^ ev);
            tap_inv   = 4'(rnd());
            ana_en    = 4'(rnd());
            ana_code  = 32'(rnd()) ^ (32'(rnd()) << 16);
            half_en   = 4'(rnd());
            for (int k = 0; k < 5; k++) begin
               tick(1'(rnd()));
               chk_model("sweep");
            end
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule